// File: doc/BRIEF.md
# Flash Read-Protection Access Controller

This block decides, for every access aimed at the flash side of a chip, whether the access may proceed. It turns a stored protection byte and its stored complement into one of three protection levels, holds that level steady between system resets, and judges each request against the level and the execution context the request comes from. The context is user code, debug, boot RAM or the boot loader. The request names a target region (main array, option bytes, system memory, backup registers) and an operation (read, program, erase).

A refused read of protected storage produces a one-cycle bus-error pulse and a fault interrupt request. A refused program or erase sets a sticky program-error flag, which software clears with a write-one-to-clear strobe. Lowering the protection level to the unprotected level issues a main-array mass-erase request and a backup-register reset for one cycle. The lower level takes effect only in the following cycle. The flash array, the option storage and the erase timing are outside this block.

Top module: `rdp_guard`

## Requirements
- R1: A byte/complement pair of 0xAA/0x55 decodes to level 0 and 0xCC/0x33 decodes to level 2. `level_o` encodes level 0, 1 and 2 as the values 0, 1 and 2.
- R2: Every other pair decodes to level 1. This covers the blank pair 0xFF/0xFF and 0xAA or 0xCC with a wrong complement. After `rst_ni`, `level_o` reads 1 until the first reload.
- R3: The active level changes only at a `reload_i` strobe, and `level_o` shows the new value one cycle later. The first reload after `rst_ni` loads the decoded level directly, with no erase.
- R4: Access encodings are as follows. `ctx_i`: 0 user, 1 debug, 2 boot RAM, 3 boot loader. `region_i`: 0 main, 1 option, 2 system, 3 backup. `op_i`: 0 read, any other value a program/erase. At level 0, every operation on the main, option and backup regions is granted in every context.
- R5: At level 1, user-context (0) accesses to the main and option regions are granted for every operation.
- R6: At level 1 or 2 in a non-user context, a read of the main region, or any access to the backup region, is refused. `rsp_vld_o`, `berr_o` and `fault_o` pulse for the cycle after the request, with `gnt_o` low.
- R7: At level 1 or 2 in a non-user context, a program/erase of the main region is refused and sets `pgerr_o`, with no bus error.
- R8: The system region grants reads at every level and context. It refuses every program/erase and sets `pgerr_o`.
- R9: `pgerr_o` stays set until a `pgerr_clr_i` strobe. A new error in the same cycle as a clear keeps it set.
- R10: A reload that lowers the level from 1 or 2 to 0, after the first load, raises `mass_erase_o` and `bkp_rst_o` for one cycle while `level_o` still shows the old level. `level_o` becomes 0 one cycle later.
- R11: At level 2, `debug_en_o` is low. A program/erase of the option region is refused and sets `pgerr_o` in every context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opt_byte_i | input | 8 | Stored protection byte |
| opt_cmp_i | input | 8 | Stored complement byte |
| reload_i | input | 1 | System-reset reload strobe |
| req_i | input | 1 | Access request valid |
| ctx_i | input | 2 | Execution context |
| region_i | input | 2 | Target region |
| op_i | input | 2 | Operation, 0 is read |
| pgerr_clr_i | input | 1 | Write-one-to-clear for the program-error flag |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| gnt_o | output | 1 | Access granted |
| berr_o | output | 1 | Bus-error pulse |
| fault_o | output | 1 | Fault interrupt request pulse |
| pgerr_o | output | 1 | Sticky program-error flag |
| mass_erase_o | output | 1 | Main-array mass-erase request |
| bkp_rst_o | output | 1 | Backup-register reset request |
| debug_en_o | output | 1 | Debug access allowed |
| level_o | output | 2 | Active protection level |

## Verification
The assertions take each request to be a single-cycle `req_i` with context, region and operation held stable in that cycle. They also take `reload_i` to be a one-cycle strobe and the option byte pair to be stable while it is high. The directed stimulus drives all inputs on the falling edge, keeps `req_i` high for exactly one cycle and always leaves an idle cycle afterwards. Reloads are issued only while no erase sequence is pending, so the one-cycle pulse and lowering properties are never exercised outside the conditions they assume.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2} level_e;
  typedef enum logic [1:0] {CTX_USER = 2'd0, CTX_DEBUG = 2'd1, CTX_BOOTRAM = 2'd2, CTX_LOADER = 2'd3} ctx_e;
  typedef enum logic [1:0] {RG_MAIN = 2'd0, RG_OPT = 2'd1, RG_SYS = 2'd2, RG_BKP = 2'd3} region_e;

  typedef struct packed {
    logic grant;
    logic berr;
    logic pgerr;
  } verdict_t;
endpackage

// File: rtl/rdp_level_decode.sv
module rdp_level_decode
  import rdp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA,
  parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hCC
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] cmp_i,
  output level_e            level_o
);
  localparam logic [BYTE_W-1:0] OPEN_CMP = ~OPEN_CODE;
  localparam logic [BYTE_W-1:0] LOCK_CMP = ~LOCK_CODE;

  logic open_hit, lock_hit;
  assign open_hit = (byte_i == OPEN_CODE) && (cmp_i == OPEN_CMP);
  assign lock_hit = (byte_i == LOCK_CODE) && (cmp_i == LOCK_CMP);

  // anything not an exact pair falls to the middle level
  always_comb begin
    if (open_hit)      level_o = LVL0;
    else if (lock_hit) level_o = LVL2;
    else               level_o = LVL1;
  end
endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
  import rdp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   reload_i,
  input  level_e dec_level_i,
  output level_e level_o,
  output logic   wipe_o
);
  typedef enum logic {ST_IDLE, ST_WIPE} state_e;

  state_e state_q;
  level_e level_q;
  logic   loaded_q;
  logic   wipe_q;
  logic   lowering;

  assign lowering = loaded_q && (dec_level_i == LVL0) && (level_q != LVL0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      level_q  <= LVL1;
      loaded_q <= 1'b0;
      wipe_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (reload_i) begin
            loaded_q <= 1'b1;
            if (lowering) begin
              state_q <= ST_WIPE;
              wipe_q  <= 1'b1;
            end else begin
              level_q <= dec_level_i;
            end
          end
        end
        default: begin
          wipe_q  <= 1'b0;
          level_q <= LVL0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign level_o = level_q;
  assign wipe_o  = wipe_q;

  p_level_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && state_q == ST_IDLE) |=> $stable(level_q));

  p_wipe_then_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_q |=> (level_q == LVL0) && !wipe_q);

  p_lower_waits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && reload_i && loaded_q && level_q == LVL1 && dec_level_i == LVL0)
    |=> wipe_q && (level_q == LVL1));
endmodule

// File: rtl/rdp_access_check.sv
module rdp_access_check
  import rdp_pkg::*;
#(
  parameter int unsigned OP_W = 2
) (
  input  level_e          level_i,
  input  ctx_e            ctx_i,
  input  region_e         region_i,
  input  logic [OP_W-1:0] op_i,
  output verdict_t        verdict_o
);
  logic restricted, is_read;

  assign restricted = (ctx_i != CTX_USER) && (level_i != LVL0);
  assign is_read    = (op_i == '0);

  always_comb begin
    verdict_o = '0;
    unique case (region_i)
      RG_SYS: begin
        if (is_read) verdict_o.grant = 1'b1;
        else         verdict_o.pgerr = 1'b1;
      end
      RG_MAIN: begin
        if (!restricted)  verdict_o.grant = 1'b1;
        else if (is_read) verdict_o.berr  = 1'b1;
        else              verdict_o.pgerr = 1'b1;
      end
      RG_OPT: begin
        if (level_i == LVL2 && !is_read) verdict_o.pgerr = 1'b1;
        else                             verdict_o.grant = 1'b1;
      end
      default: begin
        if (restricted) verdict_o.berr  = 1'b1;
        else            verdict_o.grant = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rdp_guard.sv
module rdp_guard
  import rdp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned OP_W   = 2,
  parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA,
  parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hCC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] opt_byte_i,
  input  logic [BYTE_W-1:0] opt_cmp_i,
  input  logic              reload_i,
  input  logic              req_i,
  input  logic [1:0]        ctx_i,
  input  logic [1:0]        region_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              pgerr_clr_i,
  output logic              rsp_vld_o,
  output logic              gnt_o,
  output logic              berr_o,
  output logic              fault_o,
  output logic              pgerr_o,
  output logic              mass_erase_o,
  output logic              bkp_rst_o,
  output logic              debug_en_o,
  output logic [1:0]        level_o
);
  level_e   dec_level, act_level;
  logic     wipe;
  verdict_t verdict;

  rdp_level_decode #(
    .BYTE_W(BYTE_W), .OPEN_CODE(OPEN_CODE), .LOCK_CODE(LOCK_CODE)
  ) u_decode (
    .byte_i (opt_byte_i),
    .cmp_i  (opt_cmp_i),
    .level_o(dec_level)
  );

  rdp_level_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload_i),
    .dec_level_i(dec_level),
    .level_o    (act_level),
    .wipe_o     (wipe)
  );

  rdp_access_check #(.OP_W(OP_W)) u_check (
    .level_i  (act_level),
    .ctx_i    (ctx_e'(ctx_i)),
    .region_i (region_e'(region_i)),
    .op_i     (op_i),
    .verdict_o(verdict)
  );

  logic rsp_q, gnt_q, berr_q, pgerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      gnt_q   <= 1'b0;
      berr_q  <= 1'b0;
      pgerr_q <= 1'b0;
    end else begin
      rsp_q  <= req_i;
      gnt_q  <= req_i && verdict.grant;
      berr_q <= req_i && verdict.berr;
      // new error wins over a concurrent clear
      if (req_i && verdict.pgerr) pgerr_q <= 1'b1;
      else if (pgerr_clr_i)       pgerr_q <= 1'b0;
    end
  end

  assign rsp_vld_o    = rsp_q;
  assign gnt_o        = gnt_q;
  assign berr_o       = berr_q;
  assign fault_o      = berr_q;
  assign pgerr_o      = pgerr_q;
  assign mass_erase_o = wipe;
  assign bkp_rst_o    = wipe;
  assign debug_en_o   = (act_level != LVL2);
  assign level_o      = act_level;

  p_berr_refused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> rsp_vld_o && !gnt_o);

  p_restricted_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ctx_i != 2'd0 && act_level != LVL0 && region_i == 2'd0 && op_i == '0)
    |=> berr_o && !gnt_o);

  p_restricted_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ctx_i != 2'd0 && act_level != LVL0 && region_i == 2'd0 && op_i != '0)
    |=> pgerr_o && !gnt_o && !berr_o);

  p_sys_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i == 2'd2 && op_i != '0) |=> !gnt_o && pgerr_o);

  p_pgerr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgerr_o && !pgerr_clr_i) |=> pgerr_o);

  p_lock_opt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && act_level == LVL2 && region_i == 2'd1 && op_i != '0) |=> !gnt_o && pgerr_o);

  p_open_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && act_level == LVL0 && region_i != 2'd2) |=> gnt_o);
endmodule

// File: tb/rdp_guard_tb.sv
module rdp_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opt_byte = 8'hFF, opt_cmp = 8'hFF;
  logic       reload = 1'b0, req = 1'b0, pgerr_clr = 1'b0;
  logic [1:0] ctx = '0, region = '0, op = '0;
  logic       rsp_vld, gnt, berr, fault, pgerr, mass_erase, bkp_rst, debug_en;
  logic [1:0] level;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rdp_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opt_byte_i(opt_byte), .opt_cmp_i(opt_cmp),
    .reload_i(reload), .req_i(req), .ctx_i(ctx), .region_i(region), .op_i(op),
    .pgerr_clr_i(pgerr_clr), .rsp_vld_o(rsp_vld), .gnt_o(gnt), .berr_o(berr),
    .fault_o(fault), .pgerr_o(pgerr), .mass_erase_o(mass_erase), .bkp_rst_o(bkp_rst),
    .debug_en_o(debug_en), .level_o(level)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reload_pair(logic [7:0] b, logic [7:0] c);
    @(negedge clk);
    opt_byte = b; opt_cmp = c; reload = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); reload = 1'b0;
  endtask

  // one request; samples the response one edge later
  task automatic access(int cx, int rg, int o, int e_gnt, int e_berr, string tag);
    @(negedge clk);
    req = 1'b1; ctx = 2'(cx); region = 2'(rg); op = 2'(o);
    @(posedge clk); #1;
    chk({tag, " rsp"}, rsp_vld, 1);
    chk({tag, " gnt"}, gnt, e_gnt);
    chk({tag, " berr"}, berr, e_berr);
    chk({tag, " fault"}, fault, e_berr);
    @(negedge clk); req = 1'b0;
    @(posedge clk); #1;
    chk({tag, " berr pulse"}, berr, 0);
  endtask

  task automatic clear_pgerr();
    @(negedge clk); pgerr_clr = 1'b1;
    @(negedge clk); pgerr_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset level", level, 1);
    chk("R2 reset gnt", gnt, 0);
    chk("R9 reset pgerr", pgerr, 0);
    chk("R11 reset debug", debug_en, 1);
  endtask

  task automatic t_open();
    reload_pair(8'hAA, 8'h55);
    chk("R1 open level", level, 0);
    chk("R3 first load no erase", mass_erase, 0);
    access(1, 0, 1, 1, 0, "R4 debug main prog");
    access(3, 3, 0, 1, 0, "R4 loader bkp read");
    access(2, 1, 2, 1, 0, "R4 bootram opt erase");
    access(0, 2, 1, 0, 0, "R8 sys prog L0");
    chk("R8 pgerr set", pgerr, 1);
    @(negedge clk); @(negedge clk);
    chk("R9 sticky", pgerr, 1);
    clear_pgerr();
    chk("R9 cleared", pgerr, 0);
  endtask

  task automatic t_hold();
    @(negedge clk); opt_byte = 8'hCC; opt_cmp = 8'h33;
    repeat (3) @(negedge clk);
    chk("R3 no reload hold", level, 0);
  endtask

  task automatic t_mid();
    reload_pair(8'hFF, 8'hFF);
    chk("R2 blank pair", level, 1);
    access(0, 0, 2, 1, 0, "R5 user main erase");
    access(0, 1, 1, 1, 0, "R5 user opt prog");
    access(1, 0, 0, 0, 1, "R6 debug main read");
    access(3, 3, 0, 0, 1, "R6 loader bkp read");
    chk("R6 no pgerr", pgerr, 0);
    access(2, 0, 1, 0, 0, "R7 bootram main prog");
    chk("R7 pgerr", pgerr, 1);
    clear_pgerr();
    access(1, 2, 0, 1, 0, "R8 sys read debug L1");
    // error and clear in the same cycle
    @(negedge clk);
    req = 1'b1; ctx = 2'd0; region = 2'd2; op = 2'd2; pgerr_clr = 1'b1;
    @(negedge clk); req = 1'b0; pgerr_clr = 1'b0;
    chk("R9 set wins", pgerr, 1);
    clear_pgerr();
    reload_pair(8'hAA, 8'h56);
    chk("R2 bad cmp open", level, 1);
    reload_pair(8'hCC, 8'h00);
    chk("R2 bad cmp lock", level, 1);
  endtask

  task automatic t_lock_and_lower();
    reload_pair(8'hCC, 8'h33);
    chk("R1 lock level", level, 2);
    chk("R11 debug off", debug_en, 0);
    access(0, 1, 1, 0, 0, "R11 user opt prog");
    chk("R11 pgerr", pgerr, 1);
    clear_pgerr();
    access(0, 0, 0, 1, 0, "R11 user main read");
    access(1, 3, 1, 0, 1, "R6 debug bkp write L2");
    @(negedge clk);
    opt_byte = 8'hAA; opt_cmp = 8'h55; reload = 1'b1;
    @(posedge clk); #1;
    chk("R10 erase req", mass_erase, 1);
    chk("R10 bkp rst", bkp_rst, 1);
    chk("R10 old level", level, 2);
    @(negedge clk); reload = 1'b0;
    @(posedge clk); #1;
    chk("R10 level open", level, 0);
    chk("R10 erase done", mass_erase, 0);
    chk("R10 debug back", debug_en, 1);
  endtask

  initial begin : watchdog
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_hold();
    t_mid();
    t_lock_and_lower();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule